// File: doc/BRIEF.md
# Three-Wire Tuner Control Slave

This block receives serial control words for a frequency synthesizer over a three-wire bus made of an enable line, a bus clock and a data line. All three lines are sampled by the system clock through synchronizers, and the block detects edges on the bus clock and the enable line. While enable is high, one data bit is captured on every falling edge of the bus clock, most significant bit first. The bus clock idles low, so rising edge k comes after k-1 bits have been captured.

The block counts the bits of each transfer. The count decides which of its output registers take the new data. The registers are:
- a 4-bit band-switch register;
- a 15-bit divider register;
- a group of control bits: a charge-pump current select, three test bits, two ratio-select bits (A and B) and a tuning-output disable.

The band-switch bits and, in long words, the divider bits are loaded while the word is still arriving. The length-dependent part is committed when enable falls. A synchronous reset restores the power-on state. In that state, ratio bit B takes a value set by a parameter.

The stream order is as follows:
- 4 band-switch bits;
- the divider bits, most significant first (15 bits, or 14 in the shortest word);
- a control byte of charge-pump select, test bits 2..0, ratio A, ratio B, output disable, and one spare bit.

Top module: `tuner3w_ctrl`

## Requirements
- R1: When reset is asserted, the outputs take these values on the next clock: band_sw=0, divider=0, cp_hi=1, test_bits=3'b001, ratio_a=1, ratio_b=RATIO_B_INIT, tune_off=1.
- R2: Bits are captured only while bus_en is high. Bus clock edges that occur while bus_en is low change no output and are not counted.
- R3: The first four bits of a transfer appear on band_sw (first bit at band_sw[3]) at the fifth rising bus clock edge, while bus_en is still high.
- R4: When bus_en falls after exactly 18 bits, divider takes {0, the 14 bits after the band bits} and ratio_a becomes 1.
- R5: When bus_en falls after exactly 19 bits, divider takes the 15 bits after the band bits and ratio_a becomes 0.
- R6: In a 27-bit transfer, divider takes bits 5..19 at the twentieth rising bus clock edge. When bus_en falls, the last eight bits are committed in this order: cp_hi, test_bits[2], test_bits[1], test_bits[0], ratio_a, ratio_b, tune_off, spare (ignored).
- R7: 18-bit and 19-bit transfers leave cp_hi, test_bits, ratio_b and tune_off unchanged.
- R8: A transfer of fewer than 18 bits leaves divider and all control bits unchanged.
- R9: A transfer of 20 to 26 bits, or more than 27 bits, commits nothing when bus_en falls. The divider load at the twentieth rising edge still applies.
- R10: The reset value of ratio_b follows the parameter RATIO_B_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset (power-on detector) |
| bus_en | input | 1 | Bus enable line; high frames a transfer |
| bus_clk | input | 1 | Bus clock, idles low |
| bus_dat | input | 1 | Bus data, captured on bus clock falling edges |
| band_sw | output | 4 | Band-switch register |
| divider | output | 15 | Divider register |
| cp_hi | output | 1 | Charge-pump high-current select |
| test_bits | output | 3 | Test mode bits |
| ratio_a | output | 1 | Ratio select bit A |
| ratio_b | output | 1 | Ratio select bit B |
| tune_off | output | 1 | Tuning output disable |

## Verification
The hardest case to reach is the split commit of a long word. It has to be shown that the divider changes at the twentieth rising edge, before bus_en falls, and separately that a 20-to-26-bit word takes that early load but commits no control bits at the enable fall. The bench builds each transfer from separate begin, bit-burst and end tasks. This lets it stop a word partway with enable still high, check the outputs, and then either finish the word or drop enable at an illegal length. Bus clock edges with enable low are driven straight after reset, when a miscounted fifth rising edge would show up on band_sw.

// File: rtl/tuner3w_pkg.sv
`timescale 1ns/1ps
package tuner3w_pkg;
    localparam int BAND_W   = 4;
    localparam int DIV_W    = 15;
    localparam int CTRL_W   = 8;
    localparam int TEST_W   = 3;
    localparam int LEN_SHORT = BAND_W + DIV_W - 1;      // 18
    localparam int LEN_MID   = BAND_W + DIV_W;          // 19
    localparam int LEN_LONG  = BAND_W + DIV_W + CTRL_W; // 27
    localparam int CNT_W     = $clog2(LEN_LONG + 1);
    localparam int SHIFT_W   = DIV_W;                   // enough for every commit window
    localparam int BAND_AT   = BAND_W;                  // bit count at 5th rising edge
    localparam int DIV_AT    = BAND_W + DIV_W;          // bit count at 20th rising edge

    typedef enum logic [2:0] {
        LK_SHORT, LK_18, LK_19, LK_27, LK_BAD
    } len_kind_e;

    typedef struct packed {
        logic              cp_hi;
        logic [TEST_W-1:0] test;
        logic              ratio_a;
        logic              ratio_b;
        logic              tune_off;
    } ctrl_t;

    typedef struct packed {
        logic en_lvl;
        logic en_rise;
        logic en_fall;
        logic clk_rise;
        logic clk_fall;
        logic dat;
    } bus_ev_t;

    function automatic len_kind_e classify_len(input logic [CNT_W-1:0] n);
        if (n < CNT_W'(LEN_SHORT))       return LK_SHORT;
        else if (n == CNT_W'(LEN_SHORT)) return LK_18;
        else if (n == CNT_W'(LEN_MID))   return LK_19;
        else if (n == CNT_W'(LEN_LONG))  return LK_27;
        else                             return LK_BAD;
    endfunction

    function automatic ctrl_t ctrl_from_byte(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.cp_hi    = b[7];
        c.test     = b[6:4];
        c.ratio_a  = b[3];
        c.ratio_b  = b[2];
        c.tune_off = b[1];
        return c;
    endfunction

    function automatic ctrl_t ctrl_power_on(input logic rb);
        ctrl_t c;
        c.cp_hi    = 1'b1;
        c.test     = 3'b001;
        c.ratio_a  = 1'b1;
        c.ratio_b  = rb;
        c.tune_off = 1'b1;
        return c;
    endfunction
endpackage

// File: rtl/tuner3w_sync.sv
`timescale 1ns/1ps
module tuner3w_sync
    import tuner3w_pkg::*;
#(
    parameter int STAGES = 2   // at least 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_en,
    input  logic    bus_clk,
    input  logic    bus_dat,
    output bus_ev_t ev
);
    localparam int LINES = 3;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] sync_out;
    logic [1:0]       prev;   // [1]=enable, [0]=bus clock

    assign raw = {bus_en, bus_clk, bus_dat};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign sync_out[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= sync_out[2:1];
    end

    always_comb begin
        ev.en_lvl   = sync_out[2];
        ev.en_rise  = sync_out[2] & ~prev[1];
        ev.en_fall  = ~sync_out[2] & prev[1];
        ev.clk_rise = sync_out[1] & ~prev[0];
        ev.clk_fall = ~sync_out[1] & prev[0];
        ev.dat      = sync_out[0];
    end
endmodule

// File: rtl/tuner3w_shifter.sv
`timescale 1ns/1ps
module tuner3w_shifter
    import tuner3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_lvl,
    input  logic               en_rise,
    input  logic               clk_fall,
    input  logic               dat,
    output logic [CNT_W-1:0]   cnt,
    output logic [SHIFT_W-1:0] sh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (en_rise) begin
            cnt <= '0;
        end else if (en_lvl && clk_fall) begin
            sh <= {sh[SHIFT_W-2:0], dat};
            if (cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_lvl |=> ($stable(sh) && $stable(cnt)));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1 || cnt == '0));
endmodule

// File: rtl/tuner3w_commit.sv
`timescale 1ns/1ps
module tuner3w_commit
    import tuner3w_pkg::*;
#(
    parameter bit RATIO_B_INIT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_lvl,
    input  logic               en_fall,
    input  logic               clk_rise,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [SHIFT_W-1:0] sh,
    output logic [BAND_W-1:0]  band,
    output logic [DIV_W-1:0]   divider,
    output ctrl_t              ctrl
);
    len_kind_e kind;
    logic      band_load;
    logic      div_early;

    assign kind      = classify_len(cnt);
    assign band_load = en_lvl && clk_rise && (cnt == CNT_W'(BAND_AT));
    assign div_early = en_lvl && clk_rise && (cnt == CNT_W'(DIV_AT));

    always_ff @(posedge clk) begin
        if (rst) begin
            band    <= '0;
            divider <= '0;
            ctrl    <= ctrl_power_on(RATIO_B_INIT);
        end else begin
            if (band_load) band    <= sh[BAND_W-1:0];
            if (div_early) divider <= sh[DIV_W-1:0];
            if (en_fall) begin
                case (kind)
                    LK_18: begin
                        divider      <= {1'b0, sh[DIV_W-2:0]};
                        ctrl.ratio_a <= 1'b1;
                    end
                    LK_19: begin
                        divider      <= sh[DIV_W-1:0];
                        ctrl.ratio_a <= 1'b0;
                    end
                    LK_27:   ctrl <= ctrl_from_byte(sh[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    // R3
    band_chg_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && band != $past(band)) |->
            $past(clk_rise && en_lvl && cnt == CNT_W'(BAND_AT)));

    // R8
    div_chg_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && divider != $past(divider)) |->
            $past((clk_rise && en_lvl && cnt == CNT_W'(DIV_AT)) ||
                  (en_fall && (cnt == CNT_W'(LEN_SHORT) || cnt == CNT_W'(LEN_MID)))));

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && {ctrl.cp_hi, ctrl.test, ctrl.ratio_b, ctrl.tune_off} !=
            $past({ctrl.cp_hi, ctrl.test, ctrl.ratio_b, ctrl.tune_off})) |->
            $past(en_fall && cnt == CNT_W'(LEN_LONG)));

    // R4
    short_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (en_fall && cnt == CNT_W'(LEN_SHORT)) |=>
            (divider[DIV_W-1] == 1'b0 && ctrl.ratio_a));

    // R5
    mid_ra_chk: assert property (@(posedge clk) disable iff (rst)
        (en_fall && cnt == CNT_W'(LEN_MID)) |=> !ctrl.ratio_a);
endmodule

// File: rtl/tuner3w_ctrl.sv
`timescale 1ns/1ps
module tuner3w_ctrl
    import tuner3w_pkg::*;
#(
    parameter bit RATIO_B_INIT = 1'b1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_clk,
    input  logic        bus_dat,
    output logic [3:0]  band_sw,
    output logic [14:0] divider,
    output logic        cp_hi,
    output logic [2:0]  test_bits,
    output logic        ratio_a,
    output logic        ratio_b,
    output logic        tune_off
);
    bus_ev_t            ev;
    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] sh;
    ctrl_t              ctrl;

    tuner3w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .bus_en  (bus_en),
        .bus_clk (bus_clk),
        .bus_dat (bus_dat),
        .ev      (ev)
    );

    tuner3w_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (ev.en_lvl),
        .en_rise  (ev.en_rise),
        .clk_fall (ev.clk_fall),
        .dat      (ev.dat),
        .cnt      (cnt),
        .sh       (sh)
    );

    tuner3w_commit #(.RATIO_B_INIT(RATIO_B_INIT)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (ev.en_lvl),
        .en_fall  (ev.en_fall),
        .clk_rise (ev.clk_rise),
        .cnt      (cnt),
        .sh       (sh),
        .band     (band_sw),
        .divider  (divider),
        .ctrl     (ctrl)
    );

    assign cp_hi     = ctrl.cp_hi;
    assign test_bits = ctrl.test;
    assign ratio_a   = ctrl.ratio_a;
    assign ratio_b   = ctrl.ratio_b;
    assign tune_off  = ctrl.tune_off;
endmodule

// File: tb/tb_tuner3w_ctrl.sv
`timescale 1ns/1ps
module tb_tuner3w_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_en = 1'b0, bus_clk = 1'b0, bus_dat = 1'b0;
    logic [3:0]  band_sw;
    logic [14:0] divider;
    logic        cp_hi, ratio_a, ratio_b, tune_off;
    logic [2:0]  test_bits;
    logic [3:0]  b2_band;
    logic [14:0] b2_div;
    logic        b2_cp, b2_ra, b2_rb, b2_off;
    logic [2:0]  b2_test;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tuner3w_ctrl #(.RATIO_B_INIT(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_clk(bus_clk), .bus_dat(bus_dat),
        .band_sw(band_sw), .divider(divider), .cp_hi(cp_hi), .test_bits(test_bits),
        .ratio_a(ratio_a), .ratio_b(ratio_b), .tune_off(tune_off)
    );

    tuner3w_ctrl #(.RATIO_B_INIT(1'b0)) dut_b0 (
        .clk(clk), .rst(rst), .bus_en(1'b0), .bus_clk(1'b0), .bus_dat(1'b0),
        .band_sw(b2_band), .divider(b2_div), .cp_hi(b2_cp), .test_bits(b2_test),
        .ratio_a(b2_ra), .ratio_b(b2_rb), .tune_off(b2_off)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic bus_begin();
        bus_en = 1'b1;
        tick(6);
    endtask

    task automatic bus_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            bus_dat = val[i];
            tick(3);
            bus_clk = 1'b1;
            tick(6);
            bus_clk = 1'b0;
            tick(3);
        end
    endtask

    task automatic bus_end();
        tick(6);
        bus_en = 1'b0;
        tick(10);
    endtask

    task automatic chk_ctrl(input string tag, input logic cp, input logic [2:0] t,
                            input logic ra, input logic rb, input logic off);
        chk({tag, " cp_hi"},     cp_hi,     cp);
        chk({tag, " test_bits"}, test_bits, t);
        chk({tag, " ratio_a"},   ratio_a,   ra);
        chk({tag, " ratio_b"},   ratio_b,   rb);
        chk({tag, " tune_off"},  tune_off,  off);
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(2);
    endtask

    task automatic t_reset(input string tag);
        apply_reset();
        chk({tag, " R1 band"}, band_sw, 4'h0);
        chk({tag, " R1 divider"}, divider, 15'h0);
        chk_ctrl({tag, " R1"}, 1'b1, 3'b001, 1'b1, 1'b1, 1'b1);
        chk({tag, " R10 ratio_b param 0"}, b2_rb, 1'b0);
        chk({tag, " R10 ratio_b param 1"}, ratio_b, 1'b1);
    endtask

    task automatic t_idle_clocks();
        bus_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            bus_dat = 1'b1;
            tick(3); bus_clk = 1'b1; tick(6); bus_clk = 1'b0; tick(3);
        end
        tick(6);
        chk("R2 band after idle clocks", band_sw, 4'h0);
        chk("R2 divider after idle clocks", divider, 15'h0);
    endtask

    task automatic t_word19();
        bus_begin();
        bus_bits({13'd0, 4'h5, 15'h6D2B}, 19);
        bus_end();
        chk("R5 band", band_sw, 4'h5);
        chk("R5 divider", divider, 15'h6D2B);
        chk_ctrl("R5/R7", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_word27_early();
        logic [26:0] w;
        w = {4'h3, 15'h5A5A, 8'h60};
        bus_begin();
        bus_bits({5'd0, w}, 27);
        bus_end();
        bus_begin();
        bus_bits({12'd0, w[26:7]}, 20);
        chk("R6 divider at 20th rise", divider, 15'h5A5A);
        chk("R6 band before enable fall", band_sw, 4'h3);
        bus_bits({25'd0, w[6:0]}, 7);
        bus_end();
        chk("R6 divider after fall", divider, 15'h5A5A);
        chk_ctrl("R6 control byte", 1'b0, 3'b110, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_mid_divider_before_fall();
        bus_begin();
        bus_bits({12'd0, 4'h1, 15'h0F0F, 1'b0}, 20);
        chk("R6 divider loaded with enable high", divider, 15'h0F0F);
        chk_ctrl("R6 control unchanged mid-word", 1'b0, 3'b110, 1'b0, 1'b0, 1'b0);
        bus_bits({25'd0, 7'h00}, 7);
        bus_end();
        chk_ctrl("R6 zero control byte", 1'b0, 3'b000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_word18();
        bus_begin();
        bus_bits({14'd0, 4'hA, 14'h1B3C}, 18);
        bus_end();
        chk("R4 band", band_sw, 4'hA);
        chk("R4 divider msb forced 0", divider, 15'h1B3C);
        chk_ctrl("R4/R7 retained", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_short17();
        bus_begin();
        bus_bits({27'd0, 4'h9, 1'b1}, 5);
        chk("R3 band at 5th rise, enable high", band_sw, 4'h9);
        bus_bits({20'd0, 12'hFFF}, 12);
        bus_end();
        chk("R8 divider untouched", divider, 15'h1B3C);
        chk_ctrl("R8 control untouched", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
        chk("R3 band after short word", band_sw, 4'h9);
    endtask

    task automatic t_bad22();
        bus_begin();
        bus_bits({10'd0, 4'hC, 15'h1234, 3'b111}, 22);
        bus_end();
        chk("R9 band", band_sw, 4'hC);
        chk("R9 divider from 20th rise", divider, 15'h1234);
        chk_ctrl("R9 no commit at fall", 1'b0, 3'b000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_word27_ratio();
        bus_begin();
        bus_bits({5'd0, 4'h6, 15'h4321, 8'h96}, 27);
        bus_end();
        chk("R6 divider", divider, 15'h4321);
        chk_ctrl("R6 ratio_a from word", 1'b1, 3'b001, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset("initial");
        t_idle_clocks();
        t_word19();
        t_word27_early();
        t_mid_divider_before_fall();
        t_word18();
        t_short17();
        t_bad22();
        t_word27_ratio();
        t_reset("mid-run");
        summary();
        $finish;
    end
endmodule